// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO bank

This block is one bank of general-purpose pins on a small memory-mapped register bus. Each pin has seven configuration bits: output data, interrupt mask, pull-up disable, function enable, select, direction and trigger. Every one of these bits can be read back. Every one of them is changed only through a set alias and a clear alias, so software can touch a single pin without a read-modify-write. The pad inputs pass through a two-stage synchroniser. Their synchronised levels can be read back, and they feed the interrupt detector.

The same few bits say what a pin is. It can be a plain GPIO, one of three alternate-function selects, or an interrupt source. As an interrupt source the direction bit picks the polarity and the trigger bit picks edge or level. A detected condition latches a per-pin flag whether or not the pin is masked. Flags are cleared by writing ones to a flag-clear alias. The bank interrupt line is high while any unmasked flag is set.

The bus is single-cycle. A write takes effect at the clock edge on which busWr is high. Read data is combinational from the address and the current state. Word offsets within the bank are address bits [7:4], which select the register, and bits [3:2], which select the access kind (0 = plain, 1 = set, 2 = clear).

Top module: `gpio_irq_bank`

## Requirements
- R1: Register indices 1..7 are data, mask, pull, function, select, direction and trigger. A write at offset index*16+4 ORs busWdata into that register. A write at index*16+8 clears every bit written as one. Bits written as zero keep their value. Writes to the plain offset (index*16), writes with busAddr[1:0] not 0, and writes to any other offset change nothing.
- R2: A read returns a view chosen by busAddr[7:4] alone, ignoring bits [3:0]. Index 0 is the pin levels, 1..7 are the configuration registers in the order of R1, and 8 is the flag register. Indices 9..15 read 0.
- R3: The pin view (index 0) returns the pad inputs after two register stages, not the data register. A pad change applied between two edges is visible after the second following edge.
- R4: After reset every register and flag is 0 except mask, which is all ones. bankIrq is low.
- R5: padOut always equals the data register. padOutEn is 1 for a pin exactly when its function bit is 0, its select bit is 0 and its direction bit is 1.
- R6: pullUpEn is the inverse of the pull register: a pull bit of 1 disables the pull-up.
- R7: With the function bit at 1, select 0 raises altFn1. Select 1 with trigger 0 raises altFn2. Select 1 with trigger 1 raises altFn3. With the function bit at 0 none of them is raised.
- R8: A pin with function 0, select 1 and trigger 1 is an edge source. Direction 1 detects a rising change between consecutive synchronised samples, and direction 0 a falling change. The flag bit is set at the edge after the synchronised sample changes.
- R9: A pin with function 0, select 1 and trigger 0 is a level source. Direction 1 means active high and direction 0 active low. Its flag is set at every edge while the synchronised level is active.
- R10: Flags are set regardless of mask. Writing ones at offset 0x84 clears those flags, but a condition detected in the same cycle keeps its flag set. Flags change by no other write.
- R11: bankIrq is high exactly when some pin has its flag set and its mask bit at 0.
- R12: Pins that are not interrupt sources (function 1, or select 0) never set a flag, whatever their pads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Byte offset within the bank |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Output values to the pad drivers |
| padOutEn | output | 32 | Output enables to the pad drivers |
| pullUpEn | output | 32 | Pull-up enables |
| altFn1 | output | 32 | Per-pin alternate function 1 select |
| altFn2 | output | 32 | Per-pin alternate function 2 select |
| altFn3 | output | 32 | Per-pin alternate function 3 select |
| bankIrq | output | 1 | Combined bank interrupt |

## Verification
Some properties are checked on every cycle. After a set or clear write, the written bits must show up at padOut or pullUpEn. At most one alternate select may be high per pin, and a pin with an alternate function never has its output enabled. A flag never drops without a flag-clear write. The pin view must match the pad value from two cycles earlier. bankIrq can never be high while every pin is masked. The mode-dependent behaviour is shown by the bench scenarios, compared each cycle against a behavioural model: edge polarity, level re-assertion after a clear, masked flags, ignored plain and misaligned writes, and quiet GPIO pins.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int NUM_CFG  = 7;
  localparam int CFG_DATA = 0;
  localparam int CFG_MASK = 1;
  localparam int CFG_PULL = 2;
  localparam int CFG_FUNC = 3;
  localparam int CFG_SEL  = 4;
  localparam int CFG_DIR  = 5;
  localparam int CFG_TRIG = 6;
  localparam logic [3:0] IDX_FLAG = 4'd8;
  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;

  typedef struct packed {
    logic [NUM_CFG-1:0] setReg;
    logic [NUM_CFG-1:0] clrReg;
    logic               flagClr;
  } gpbStrobe_t;
endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
(
  input  logic       busWr,
  input  logic [7:0] busAddr,
  output gpbStrobe_t stb,
  output logic [3:0] rdIdx
);
  logic [3:0] idx;
  logic [1:0] op;
  logic       wrOk;

  assign idx   = busAddr[7:4];
  assign op    = busAddr[3:2];
  assign wrOk  = busWr && (busAddr[1:0] == 2'b00);
  assign rdIdx = idx;

  genvar r;
  generate
    for (r = 0; r < NUM_CFG; r++) begin : g_dec
      assign stb.setReg[r] = wrOk && (idx == 4'(r + 1)) && (op == OP_SET);
      assign stb.clrReg[r] = wrOk && (idx == 4'(r + 1)) && (op == OP_CLR);
    end
  endgenerate

  assign stb.flagClr = wrOk && (idx == IDX_FLAG) && (op == OP_SET);
endmodule

// File: rtl/gpb_dp.sv
module gpb_dp
  import gpb_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  gpbStrobe_t      stb,
  input  logic [PINS-1:0] wdata,
  input  logic [3:0]      rdIdx,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOutEn,
  output logic [PINS-1:0] pullUpEn,
  output logic [PINS-1:0] altFn1,
  output logic [PINS-1:0] altFn2,
  output logic [PINS-1:0] altFn3,
  output logic            bankIrq
);
  logic [PINS-1:0] cfgQ [NUM_CFG];
  logic [PINS-1:0] syncA, syncB, syncPrev;
  logic [PINS-1:0] flagQ, hit;

  // configuration registers: set alias ORs, clear alias knocks out ones
  genvar r;
  generate
    for (r = 0; r < NUM_CFG; r++) begin : g_cfg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cfgQ[r] <= (r == CFG_MASK) ? {PINS{1'b1}} : {PINS{1'b0}};
        else if (stb.setReg[r])
          cfgQ[r] <= cfgQ[r] | wdata;
        else if (stb.clrReg[r])
          cfgQ[r] <= cfgQ[r] & ~wdata;
      end
    end
  endgenerate

  // two-stage pad synchroniser plus one sample of history for edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  // per-pin mode decode and detection
  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      logic fn, sel, dir, trig, isIrq, rise, fall, lvl;
      assign fn    = cfgQ[CFG_FUNC][p];
      assign sel   = cfgQ[CFG_SEL][p];
      assign dir   = cfgQ[CFG_DIR][p];
      assign trig  = cfgQ[CFG_TRIG][p];
      assign isIrq = !fn && sel;
      assign rise  = syncB[p] && !syncPrev[p];
      assign fall  = !syncB[p] && syncPrev[p];
      assign lvl   = (syncB[p] == dir);
      assign hit[p] = isIrq && (trig ? (dir ? rise : fall) : lvl);

      assign padOutEn[p] = !fn && !sel && dir;
      assign altFn1[p]   = fn && !sel;
      assign altFn2[p]   = fn && sel && !trig;
      assign altFn3[p]   = fn && sel && trig;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flagQ <= '0;
    else
      flagQ <= (flagQ & ~(stb.flagClr ? wdata : {PINS{1'b0}})) | hit;
  end

  assign padOut   = cfgQ[CFG_DATA];
  assign pullUpEn = ~cfgQ[CFG_PULL];
  assign bankIrq  = |(flagQ & ~cfgQ[CFG_MASK]);

  always_comb begin
    rdata = '0;
    if (rdIdx == 4'd0) rdata = syncB;
    if (rdIdx == IDX_FLAG) rdata = flagQ;
    for (int k = 0; k < NUM_CFG; k++)
      if (rdIdx == 4'(k + 1)) rdata = cfgQ[k];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpb_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic [7:0]      busAddr,
  input  logic [PINS-1:0] busWdata,
  output logic [PINS-1:0] busRdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOutEn,
  output logic [PINS-1:0] pullUpEn,
  output logic [PINS-1:0] altFn1,
  output logic [PINS-1:0] altFn2,
  output logic [PINS-1:0] altFn3,
  output logic            bankIrq
);
  gpbStrobe_t stb;
  logic [3:0] rdIdx;

  gpb_ctrl ctrl_i (
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb),
    .rdIdx   (rdIdx)
  );

  gpb_dp #(.PINS(PINS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (busWdata),
    .rdIdx    (rdIdx),
    .padIn    (padIn),
    .rdata    (busRdata),
    .padOut   (padOut),
    .padOutEn (padOutEn),
    .pullUpEn (pullUpEn),
    .altFn1   (altFn1),
    .altFn2   (altFn2),
    .altFn3   (altFn3),
    .bankIrq  (bankIrq)
  );
endmodule

// File: rtl/gpb_chk.sv
module gpb_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            busWr,
  input logic [7:0]      busAddr,
  input logic [PINS-1:0] busWdata,
  input logic [PINS-1:0] busRdata,
  input logic [PINS-1:0] padIn,
  input logic [PINS-1:0] padOut,
  input logic [PINS-1:0] padOutEn,
  input logic [PINS-1:0] pullUpEn,
  input logic [PINS-1:0] altFn1,
  input logic [PINS-1:0] altFn2,
  input logic [PINS-1:0] altFn3,
  input logic            bankIrq,
  input logic [PINS-1:0] flagQ,
  input logic [PINS-1:0] maskQ
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_data_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h14) |=> ((padOut & $past(busWdata)) == $past(busWdata)));

  p_data_clr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h18) |=> ((padOut & $past(busWdata)) == '0));

  p_pull_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h34) |=> ((pullUpEn & $past(busWdata)) == '0));

  p_alt_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((altFn1 & altFn2) == '0) && ((altFn1 & altFn3) == '0) && ((altFn2 & altFn3) == '0));

  p_alt_no_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((padOutEn & (altFn1 | altFn2 | altFn3)) == '0));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == 8'h84) |=> (($past(flagQ) & ~flagQ) == '0));

  p_pin_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && busAddr[7:4] == 4'd0) |-> (busRdata == $past(padIn, 2)));

  p_irq_unmasked_r11: assert property (@(posedge clk) disable iff (!rstN)
    bankIrq |-> (maskQ != {PINS{1'b1}}));
endmodule

bind gpio_irq_bank gpb_chk #(.PINS(PINS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOutEn (padOutEn),
  .pullUpEn (pullUpEn),
  .altFn1   (altFn1),
  .altFn2   (altFn2),
  .altFn3   (altFn3),
  .bankIrq  (bankIrq),
  .flagQ    (dp_i.flagQ),
  .maskQ    (dp_i.cfgQ[1])
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] padIn = '0;
  logic [31:0] busRdata, padOut, padOutEn, pullUpEn, altFn1, altFn2, altFn3;
  logic        bankIrq;

  always #4 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOutEn(padOutEn),
    .pullUpEn(pullUpEn), .altFn1(altFn1), .altFn2(altFn2), .altFn3(altFn3),
    .bankIrq(bankIrq)
  );

  // behavioural reference state
  logic [31:0] mData, mMask, mPull, mFunc, mSel, mDir, mTrig, mFlag;
  logic [31:0] q1, q2, q3;
  int    vecCnt = 0;
  int    errCnt = 0;
  int    cycles = 0;
  bit    done = 0;
  string curTag = "R4";
  logic [31:0] curPad = '0;

  task automatic mReset();
    mData = '0; mMask = '1; mPull = '0; mFunc = '0; mSel = '0; mDir = '0;
    mTrig = '0; mFlag = '0; q1 = '0; q2 = '0; q3 = '0;
  endtask

  function automatic logic [31:0] mView(input logic [7:0] a);
    case (a[7:4])
      4'd0: return q2;
      4'd1: return mData;
      4'd2: return mMask;
      4'd3: return mPull;
      4'd4: return mFunc;
      4'd5: return mSel;
      4'd6: return mDir;
      4'd7: return mTrig;
      4'd8: return mFlag;
      default: return 32'h0;
    endcase
  endfunction

  task automatic mClock();
    logic [31:0] det;
    det = '0;
    for (int i = 0; i < 32; i++) begin
      if (!mFunc[i] && mSel[i]) begin
        if (mTrig[i]) begin
          if (mDir[i]) det[i] = q2[i] && !q3[i];
          else         det[i] = !q2[i] && q3[i];
        end else begin
          det[i] = (q2[i] == mDir[i]);
        end
      end
    end
    if (busWr && busAddr == 8'h84) mFlag = mFlag & ~busWdata;
    mFlag = mFlag | det;
    if (busWr && busAddr[1:0] == 2'b00) begin
      logic [31:0] setW, clrW;
      setW = (busAddr[3:2] == 2'd1) ? busWdata : 32'h0;
      clrW = (busAddr[3:2] == 2'd2) ? busWdata : 32'h0;
      case (busAddr[7:4])
        4'd1: mData = (mData | setW) & ~clrW;
        4'd2: mMask = (mMask | setW) & ~clrW;
        4'd3: mPull = (mPull | setW) & ~clrW;
        4'd4: mFunc = (mFunc | setW) & ~clrW;
        4'd5: mSel  = (mSel  | setW) & ~clrW;
        4'd6: mDir  = (mDir  | setW) & ~clrW;
        4'd7: mTrig = (mTrig | setW) & ~clrW;
        default: ;
      endcase
    end
    q3 = q2; q2 = q1; q1 = padIn;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    string rtag;
    rtag = (busAddr[7:4] == 4'd0) ? "R3" : (busAddr[7:4] == 4'd8) ? "R10" : curTag;
    check(rtag, "busRdata", busRdata, mView(busAddr));
    check("R5", "padOut", padOut, mData);
    check("R5", "padOutEn", padOutEn, mDir & ~mFunc & ~mSel);
    check("R6", "pullUpEn", pullUpEn, ~mPull);
    check("R7", "altFn1", altFn1, mFunc & ~mSel);
    check("R7", "altFn2", altFn2, mFunc & mSel & ~mTrig);
    check("R7", "altFn3", altFn3, mFunc & mSel & mTrig);
    check("R11", "bankIrq", {31'h0, bankIrq}, {31'h0, |(mFlag & ~mMask)});
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    compareAll();
    busWr = wr; busAddr = a; busWdata = d; padIn = curPad;
    @(posedge clk);
    mClock();
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic idle(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) step(1'b0, a, 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errCnt++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    busAddr = 8'h20;
    #1;
    // R4: reset values
    check("R4", "mask after reset", busRdata, 32'hFFFF_FFFF);
    check("R4", "bankIrq after reset", {31'h0, bankIrq}, 32'h0);
    rstN = 1'b1;
    @(posedge clk);
    mClock();
    curTag = "R4";
    idle(8'h10, 1); idle(8'h40, 1); idle(8'h80, 1);

    // R1: set/clear aliases, ignored plain and misaligned writes
    curTag = "R1";
    wr32(8'h14, 32'h0000_00F0);
    wr32(8'h18, 32'h0000_0030);
    wr32(8'h10, 32'hFFFF_FFFF);
    wr32(8'h15, 32'hFFFF_0000);
    wr32(8'h1C, 32'hFFFF_FFFF);
    wr32(8'h94, 32'hFFFF_FFFF);
    idle(8'h10, 2);
    // R2: read view ignores low address bits; high indices read zero
    curTag = "R2";
    idle(8'h1C, 1); idle(8'h2A, 1); idle(8'hF0, 1);

    // R5: GPIO output enables
    curTag = "R5";
    wr32(8'h64, 32'h0000_00FF);
    idle(8'h60, 2);
    // R6: pull register
    curTag = "R6";
    wr32(8'h34, 32'h0000_0F0F);
    wr32(8'h38, 32'h0000_0003);
    idle(8'h30, 1);
    // R7: alternate functions on pins 8..10; pin 0 output goes away when function set
    curTag = "R7";
    wr32(8'h44, 32'h0000_0701);
    wr32(8'h54, 32'h0000_0600);
    wr32(8'h74, 32'h0000_0400);
    idle(8'h40, 2);

    // R3: pad sampling through two stages
    curTag = "R3";
    curPad = 32'hA5A5_0F0F;
    idle(8'h00, 4);

    // R8: edge sources, pin 16 rising, pin 17 falling, unmasked
    curTag = "R8";
    curPad = 32'h0000_0000;
    idle(8'h00, 3);
    wr32(8'h54, 32'h0003_0000);
    wr32(8'h74, 32'h0003_0000);
    wr32(8'h64, 32'h0001_0000);
    wr32(8'h28, 32'h0003_0000);
    idle(8'h80, 2);
    curPad = 32'h0003_0000;
    idle(8'h80, 4);
    wr32(8'h84, 32'h0003_0000);
    idle(8'h80, 2);
    curPad = 32'h0000_0000;
    idle(8'h80, 4);
    wr32(8'h84, 32'hFFFF_FFFF);
    idle(8'h80, 2);

    // R9: level sources, pin 20 high-active, pin 21 low-active (masked)
    curTag = "R9";
    wr32(8'h54, 32'h0030_0000);
    wr32(8'h64, 32'h0010_0000);
    wr32(8'h28, 32'h0010_0000);
    idle(8'h80, 2);
    curPad = 32'h0010_0000;
    idle(8'h80, 4);
    // R10: clear while level persists keeps the flag; masked pin 21 flags without irq
    curTag = "R10";
    wr32(8'h84, 32'h0030_0000);
    idle(8'h80, 2);
    curPad = 32'h0020_0000;
    idle(8'h80, 4);
    wr32(8'h84, 32'h0030_0000);
    wr32(8'h80, 32'hFFFF_FFFF);
    wr32(8'h88, 32'hFFFF_FFFF);
    idle(8'h80, 2);

    // R12: GPIO and alternate-function pins never flag
    curTag = "R12";
    wr32(8'h58, 32'hFFFF_FFFF);
    wr32(8'h84, 32'hFFFF_FFFF);
    wr32(8'h24, 32'hFFFF_FFFF);
    wr32(8'h28, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) begin
      curPad = ~curPad;
      idle(8'h80, 3);
    end

    // mixed traffic against the model
    curTag = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      a = {4'($urandom_range(0, 8)), 2'($urandom_range(0, 2)), ($urandom_range(0, 9) == 0) ? 2'b01 : 2'b00};
      if (i % 5 == 0) curPad = $urandom;
      step(($urandom_range(0, 1) == 1), a, $urandom);
    end
    @(negedge clk);
    compareAll();
    finishRun();
  end
endmodule